// File: doc/BRIEF.md
# Error Signalling Classifier

This block sits behind the error detectors of one link function and turns each detected error event into at most one outgoing error message. Every cycle it may take one event consisting of a status vector, a flag that says whether the event belongs to the correctable class, a flag that lets a non-fatal uncorrectable error be demoted to an advisory correctable one, and a 16-bit source identifier. It strips the status vector down to the bits its class supports and rejects the event unless exactly one bit remains. It then updates the sticky correctable and uncorrectable status vectors and the four device status bits. It applies the mask and severity settings, and it decides from the reporting enables whether a message of correctable, non-fatal or fatal severity leaves the block.

Uncorrectable errors that are not masked ask the surrounding logic to record their header (`log_req`). When the header store reports that it is full at that moment, the block runs a follow-up: in the next cycle it processes a header-log-overflow correctable error of its own, carrying the source identifier of the event that overflowed. The controller has two states. `ST_ACCEPT` is the normal state, in which `evt_ready` is high. It moves to `ST_OVFL` when an accepted event requests a record while `log_full` is high. `ST_OVFL` processes the synthetic event, holds `evt_ready` low and always returns to `ST_ACCEPT` on the next clock.

The mask, severity and enable settings are plain input levels. After power-up the severity input is expected to carry 0x0046_2030, which makes bits 4, 5, 13, 17, 18 and 22 fatal and the other uncorrectable bits non-fatal.

Top module: `aer_err_classifier`

## Requirements
- R1: Correctable status is ANDed with 0x0000_F1C1 (bits 0, 6, 7, 8, 12, 13, 14, 15) and uncorrectable status with 0x03FF_F030 (bits 4, 5, 12..25). If not exactly one bit remains, `evt_reject` pulses one cycle later and no status, log request or message results.
- R2: Any event taking the correctable path sets `dev_status[0]`. An unsupported-request event (uncorrectable bit 20) additionally sets `dev_status[3]` on either path.
- R3: A correctable-path event sets its bit in `cor_status`. If that bit is set in `cfg_cor_mask`, no message follows and nothing else happens. The status vectors are sticky until reset.
- R4: An uncorrectable event is fatal exactly when its bit is set in `cfg_unc_sev`. With the power-up value 0x0046_2030, bit 18 is fatal and bit 12 is non-fatal.
- R5: A non-fatal uncorrectable event with `evt_advisory` high goes down the correctable path as bit 13 of `cor_status`. Its original bit is set in `unc_status` and a record is requested only when that bit is clear in `cfg_unc_mask`. A fatal event ignores `evt_advisory`.
- R6: An uncorrectable-path event sets `dev_status[2]` (fatal) or `dev_status[1]` (non-fatal) and its bit in `unc_status`. When its bit is masked in `cfg_unc_mask`, no record is requested and no message is sent. Otherwise `log_req` pulses.
- R7: An unmasked uncorrectable message is sent only if `cfg_serr_en` is high or the matching enable is high: `cfg_fat_rpt_en` for fatal, `cfg_nf_rpt_en` for non-fatal.
- R8: With `cfg_ur_rpt_en` low, an unsupported request produces no message on the correctable path. On the uncorrectable path it produces no message only if `cfg_serr_en` is also low.
- R9: A correctable-path message additionally requires `cfg_cor_rpt_en`.
- R10: When a record is requested while `log_full` is high, the next cycle processes a correctable error at bit 15 (header log overflow) through the same path, using the overflowing event's source identifier.
- R11: A message is a one-cycle `msg_valid` pulse, one cycle after the event is accepted. `msg_sev` is one-hot (bit 0 correctable, bit 1 non-fatal, bit 2 fatal) and zero otherwise, and `msg_source` carries the event's identifier.
- R12: `evt_ready` is low for exactly the one cycle that the overflow follow-up occupies. An event offered in that cycle is not taken.
- R13: After reset all outputs are zero except `evt_ready`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event offered |
| evt_ready | output | 1 | Event accepted this cycle when high |
| evt_status | input | 32 | Raw error status vector |
| evt_correctable | input | 1 | Event belongs to the correctable class |
| evt_advisory | input | 1 | Non-fatal event may be demoted to advisory |
| evt_source | input | 16 | Source identifier of the event |
| cfg_cor_mask | input | 32 | Correctable mask |
| cfg_unc_mask | input | 32 | Uncorrectable mask |
| cfg_unc_sev | input | 32 | Uncorrectable severity, 1 = fatal |
| cfg_serr_en | input | 1 | System error enable |
| cfg_cor_rpt_en | input | 1 | Correctable reporting enable |
| cfg_nf_rpt_en | input | 1 | Non-fatal reporting enable |
| cfg_fat_rpt_en | input | 1 | Fatal reporting enable |
| cfg_ur_rpt_en | input | 1 | Unsupported-request reporting enable |
| log_full | input | 1 | Header store cannot take a record |
| log_req | output | 1 | Header record requested (pulse) |
| evt_reject | output | 1 | Event was invalid (pulse) |
| msg_valid | output | 1 | Error message emitted (pulse) |
| msg_sev | output | 3 | One-hot message severity |
| msg_source | output | 16 | Message source identifier |
| cor_status | output | 32 | Sticky correctable status |
| unc_status | output | 32 | Sticky uncorrectable status |
| dev_status | output | 4 | Sticky detected bits: correctable, non-fatal, fatal, unsupported request |

## Verification
Every result of an accepted event (message, log request, reject pulse, status vectors) is registered once, so it is due exactly one clock after the accepting edge. The overflow follow-up result is due one clock later than that, and `evt_ready` drops in the same cycle as the result of the overflowing event. The bench drives inputs on the falling edge. Its model consumes them on the rising edge, and every output is compared with the model on the following falling edge. Directed checks read the outputs on that same falling edge, after each event.

// File: rtl/aer_cls_pkg.sv
package aer_cls_pkg;
    localparam int STAT_W = 32;
    localparam int SRC_W  = 16;
    localparam int SEV_W  = 3;
    localparam int DEV_W  = 4;

    // supported bits per class
    localparam logic [STAT_W-1:0] COR_SUP = 32'h0000_F1C1;
    localparam logic [STAT_W-1:0] UNC_SUP = 32'h03FF_F030;
    // bits with a fixed meaning
    localparam logic [STAT_W-1:0] UR_BIT  = 32'h0010_0000;
    localparam logic [STAT_W-1:0] ADV_BIT = 32'h0000_2000;
    localparam logic [STAT_W-1:0] HLO_BIT = 32'h0000_8000;
    localparam int HLO_POS = 15;

    // message severity, one-hot
    localparam logic [SEV_W-1:0] SEV_COR = 3'b001;
    localparam logic [SEV_W-1:0] SEV_NF  = 3'b010;
    localparam logic [SEV_W-1:0] SEV_FAT = 3'b100;

    // device status bit positions
    localparam int DS_COR = 0;
    localparam int DS_NF  = 1;
    localparam int DS_FAT = 2;
    localparam int DS_UR  = 3;

    typedef struct packed {
        logic              one;
        logic              cor_path;
        logic              fatal;
        logic              ur;
        logic              adv;
        logic [STAT_W-1:0] hit;
        logic [STAT_W-1:0] cbit;
    } dec_t;

    typedef enum logic {ST_ACCEPT, ST_OVFL} st_e;
endpackage

// File: rtl/aer_cls_decode.sv
module aer_cls_decode
    import aer_cls_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    input  logic              corr,
    input  logic              adv_req,
    input  logic [STAT_W-1:0] sev,
    output dec_t              dec
);
    logic [STAT_W-1:0] kept;

    always_comb begin
        kept         = status & (corr ? COR_SUP : UNC_SUP);
        dec          = '0;
        dec.hit      = kept;
        dec.one      = $onehot(kept);
        dec.fatal    = !corr && (|(kept & sev));
        dec.ur       = !corr && (kept == UR_BIT);
        dec.adv      = !corr && !dec.fatal && adv_req;
        dec.cor_path = corr || dec.adv;
        dec.cbit     = corr ? kept : (dec.adv ? ADV_BIT : '0);
    end
endmodule

// File: rtl/aer_cls_route.sv
module aer_cls_route
    import aer_cls_pkg::*;
(
    input  dec_t              dec,
    input  logic              go,
    input  logic [STAT_W-1:0] cor_mask,
    input  logic [STAT_W-1:0] unc_mask,
    input  logic              serr_en,
    input  logic              cor_en,
    input  logic              nf_en,
    input  logic              fat_en,
    input  logic              ur_en,
    input  logic              log_full,
    output logic [STAT_W-1:0] cor_set,
    output logic [STAT_W-1:0] unc_set,
    output logic [DEV_W-1:0]  dev_set,
    output logic              send,
    output logic [SEV_W-1:0]  sev,
    output logic              log,
    output logic              ovfl,
    output logic              reject
);
    always_comb begin
        cor_set = '0;
        unc_set = '0;
        dev_set = '0;
        send    = 1'b0;
        sev     = '0;
        log     = 1'b0;
        reject  = go && !dec.one;
        if (go && dec.one) begin
            dev_set[DS_UR] = dec.ur;
            if (dec.cor_path) begin
                dev_set[DS_COR] = 1'b1;
                cor_set         = dec.cbit;
                if (!(|(dec.cbit & cor_mask))) begin
                    if (dec.adv && !(|(dec.hit & unc_mask))) begin
                        log     = 1'b1;
                        unc_set = dec.hit;
                    end
                    send = cor_en && !(dec.ur && !ur_en);
                    sev  = SEV_COR;
                end
            end else begin
                dev_set[DS_FAT] = dec.fatal;
                dev_set[DS_NF]  = !dec.fatal;
                unc_set         = dec.hit;
                if (!(|(dec.hit & unc_mask))) begin
                    log  = 1'b1;
                    send = !(dec.ur && !ur_en && !serr_en) &&
                           (serr_en || (dec.fatal ? fat_en : nf_en));
                    sev  = dec.fatal ? SEV_FAT : SEV_NF;
                end
            end
        end
        if (!send) sev = '0;
        ovfl = log && log_full;
    end
endmodule

// File: rtl/aer_err_classifier.sv
module aer_err_classifier
    import aer_cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [STAT_W-1:0] evt_status,
    input  logic              evt_correctable,
    input  logic              evt_advisory,
    input  logic [SRC_W-1:0]  evt_source,
    input  logic [STAT_W-1:0] cfg_cor_mask,
    input  logic [STAT_W-1:0] cfg_unc_mask,
    input  logic [STAT_W-1:0] cfg_unc_sev,
    input  logic              cfg_serr_en,
    input  logic              cfg_cor_rpt_en,
    input  logic              cfg_nf_rpt_en,
    input  logic              cfg_fat_rpt_en,
    input  logic              cfg_ur_rpt_en,
    input  logic              log_full,
    output logic              log_req,
    output logic              evt_reject,
    output logic              msg_valid,
    output logic [SEV_W-1:0]  msg_sev,
    output logic [SRC_W-1:0]  msg_source,
    output logic [STAT_W-1:0] cor_status,
    output logic [STAT_W-1:0] unc_status,
    output logic [DEV_W-1:0]  dev_status
);
    st_e               state_q, state_d;
    logic [SRC_W-1:0]  src_q;
    logic              in_ovfl, go;
    logic [STAT_W-1:0] cur_status;
    logic              cur_corr, cur_adv;
    logic [SRC_W-1:0]  cur_src;
    dec_t              dec;
    logic [STAT_W-1:0] cor_set, unc_set;
    logic [DEV_W-1:0]  dev_set;
    logic              send, log, ovfl, reject;
    logic [SEV_W-1:0]  sev;

    assign in_ovfl    = (state_q == ST_OVFL);
    assign evt_ready  = !in_ovfl;
    assign go         = in_ovfl || evt_valid;
    assign cur_status = in_ovfl ? HLO_BIT : evt_status;
    assign cur_corr   = in_ovfl || evt_correctable;
    assign cur_adv    = !in_ovfl && evt_advisory;
    assign cur_src    = in_ovfl ? src_q : evt_source;

    aer_cls_decode u_decode (
        .status (cur_status),
        .corr   (cur_corr),
        .adv_req(cur_adv),
        .sev    (cfg_unc_sev),
        .dec    (dec)
    );

    aer_cls_route u_route (
        .dec     (dec),
        .go      (go),
        .cor_mask(cfg_cor_mask),
        .unc_mask(cfg_unc_mask),
        .serr_en (cfg_serr_en),
        .cor_en  (cfg_cor_rpt_en),
        .nf_en   (cfg_nf_rpt_en),
        .fat_en  (cfg_fat_rpt_en),
        .ur_en   (cfg_ur_rpt_en),
        .log_full(log_full),
        .cor_set (cor_set),
        .unc_set (unc_set),
        .dev_set (dev_set),
        .send    (send),
        .sev     (sev),
        .log     (log),
        .ovfl    (ovfl),
        .reject  (reject)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT: if (ovfl) state_d = ST_OVFL;
            ST_OVFL:   state_d = ST_ACCEPT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACCEPT;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ovfl) src_q <= cur_src;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid  <= 1'b0;
            msg_sev    <= '0;
            msg_source <= '0;
            log_req    <= 1'b0;
            evt_reject <= 1'b0;
            cor_status <= '0;
            unc_status <= '0;
            dev_status <= '0;
        end else begin
            msg_valid  <= send;
            msg_sev    <= sev;
            msg_source <= send ? cur_src : '0;
            log_req    <= log;
            evt_reject <= reject;
            cor_status <= cor_status | cor_set;
            unc_status <= unc_status | unc_set;
            dev_status <= dev_status | dev_set;
        end
    end

    assert_sev_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $onehot(msg_sev));
    assert_sev_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> (msg_sev == '0));
    assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reject |-> (!msg_valid && !log_req));
    assert_cor_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cor_status & $past(cor_status)) == $past(cor_status)));
    assert_unc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((unc_status & $past(unc_status)) == $past(unc_status)));
    assert_stall_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_ready) |=> evt_ready);
    assert_ovfl_logged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_ready |=> cor_status[HLO_POS]);
endmodule

// File: tb/aer_err_classifier_tb.sv
module aer_err_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;
    localparam logic [31:0] T_COR_SUP = 32'h0000_F1C1;
    localparam logic [31:0] T_UNC_SUP = 32'h03FF_F030;
    localparam logic [31:0] T_SEV_DEF = 32'h0046_2030;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0, evt_correctable = 1'b0, evt_advisory = 1'b0;
    logic [31:0] evt_status = '0;
    logic [15:0] evt_source = '0;
    logic [31:0] cfg_cor_mask = '0, cfg_unc_mask = '0, cfg_unc_sev = T_SEV_DEF;
    logic cfg_serr_en = 1'b0, cfg_cor_rpt_en = 1'b1, cfg_nf_rpt_en = 1'b1;
    logic cfg_fat_rpt_en = 1'b1, cfg_ur_rpt_en = 1'b1, log_full = 1'b0;
    logic evt_ready, log_req, evt_reject, msg_valid;
    logic [2:0] msg_sev;
    logic [15:0] msg_source;
    logic [31:0] cor_status, unc_status;
    logic [3:0] dev_status;

    int checks = 0, errors = 0, cyc = 0;
    bit armed = 0, done = 0;

    // model state
    bit e_msg_v, e_log, e_rej, m_pend;
    logic [2:0] e_sev;
    logic [15:0] e_src, m_src;
    logic [31:0] e_cor, e_unc;
    logic [3:0] e_dev;

    always #(CLK_PERIOD/2) clk = ~clk;

    aer_err_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_status(evt_status), .evt_correctable(evt_correctable),
        .evt_advisory(evt_advisory), .evt_source(evt_source),
        .cfg_cor_mask(cfg_cor_mask), .cfg_unc_mask(cfg_unc_mask),
        .cfg_unc_sev(cfg_unc_sev), .cfg_serr_en(cfg_serr_en),
        .cfg_cor_rpt_en(cfg_cor_rpt_en), .cfg_nf_rpt_en(cfg_nf_rpt_en),
        .cfg_fat_rpt_en(cfg_fat_rpt_en), .cfg_ur_rpt_en(cfg_ur_rpt_en),
        .log_full(log_full), .log_req(log_req), .evt_reject(evt_reject),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_source(msg_source),
        .cor_status(cor_status), .unc_status(unc_status), .dev_status(dev_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic emit(input logic [2:0] s, input logic [15:0] src);
        e_msg_v = 1; e_sev = s; e_src = src;
    endtask

    task automatic note_log(input logic [15:0] src);
        e_log = 1;
        if (log_full) begin m_pend = 1; m_src = src; end
    endtask

    // behavioural reference of one event
    task automatic m_event(input logic [31:0] st, input bit corr, input bit adv, input logic [15:0] src);
        logic [31:0] w, cb;
        bit fat, ur, advp;
        w = st & (corr ? T_COR_SUP : T_UNC_SUP);
        if ($countones(w) != 1) begin e_rej = 1; return; end
        fat  = !corr && ((w & cfg_unc_sev) != 0);
        ur   = !corr && (w == 32'h0010_0000);
        advp = !corr && !fat && adv;
        if (ur) e_dev[3] = 1;
        if (corr || advp) begin
            e_dev[0] = 1;
            cb = corr ? w : 32'h0000_2000;
            e_cor |= cb;
            if ((cb & cfg_cor_mask) != 0) return;
            if (advp && ((w & cfg_unc_mask) == 0)) begin e_unc |= w; note_log(src); end
            if (ur && !cfg_ur_rpt_en) return;
            if (!cfg_cor_rpt_en) return;
            emit(3'b001, src);
        end else begin
            if (fat) e_dev[2] = 1; else e_dev[1] = 1;
            e_unc |= w;
            if ((w & cfg_unc_mask) != 0) return;
            note_log(src);
            if (ur && !cfg_ur_rpt_en && !cfg_serr_en) return;
            if (!(cfg_serr_en || (fat ? cfg_fat_rpt_en : cfg_nf_rpt_en))) return;
            emit(fat ? 3'b100 : 3'b010, src);
        end
    endtask

    always @(posedge clk) begin
        armed <= 1;
        e_msg_v = 0; e_sev = 0; e_src = 0; e_log = 0; e_rej = 0;
        if (!rst_n) begin
            e_cor = 0; e_unc = 0; e_dev = 0; m_pend = 0; m_src = 0;
        end else if (m_pend) begin
            m_pend = 0;
            m_event(32'h0000_8000, 1, 0, m_src);
        end else if (evt_valid) begin
            m_event(evt_status, evt_correctable, evt_advisory, evt_source);
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R11 msg_valid", {31'b0, msg_valid}, {31'b0, e_msg_v});
            chk("R11 msg_sev", {29'b0, msg_sev}, {29'b0, e_sev});
            chk("R11 msg_source", {16'b0, msg_source}, {16'b0, e_src});
            chk("R6 log_req", {31'b0, log_req}, {31'b0, e_log});
            chk("R1 evt_reject", {31'b0, evt_reject}, {31'b0, e_rej});
            chk("R3 cor_status", cor_status, e_cor);
            chk("R6 unc_status", unc_status, e_unc);
            chk("R2 dev_status", {28'b0, dev_status}, {28'b0, e_dev});
            chk("R12 evt_ready", {31'b0, evt_ready}, {31'b0, !m_pend});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        cfg_cor_mask = 0; cfg_unc_mask = 0; cfg_unc_sev = T_SEV_DEF;
        cfg_serr_en = 0; cfg_cor_rpt_en = 1; cfg_nf_rpt_en = 1;
        cfg_fat_rpt_en = 1; cfg_ur_rpt_en = 1; log_full = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // drive one event for one cycle; returns on the falling edge where results show
    task automatic send(input logic [31:0] st, input bit corr, input bit adv, input logic [15:0] src);
        @(negedge clk);
        evt_valid = 1; evt_status = st; evt_correctable = corr;
        evt_advisory = adv; evt_source = src;
        @(negedge clk);
        evt_valid = 0; evt_status = 0; evt_correctable = 0; evt_advisory = 0;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R13 reset state
        chk("R13 msg_valid", {31'b0, msg_valid}, 0);
        chk("R13 status", cor_status | unc_status | {28'b0, dev_status}, 0);
        chk("R13 evt_ready", {31'b0, evt_ready}, 1);

        // R1 invalid and stripped events
        send(32'h0000_0010, 1, 0, 16'h0101);
        chk("R1 unsupported bit rejected", {31'b0, evt_reject}, 1);
        chk("R1 no status", cor_status, 0);
        send(32'h0000_00C0, 1, 0, 16'h0102);
        chk("R1 two bits rejected", {31'b0, evt_reject}, 1);
        send(32'h0000_0003, 1, 0, 16'h0103);
        chk("R1 stripped to one bit", cor_status, 32'h1);

        // R2, R3, R9 correctable path
        send(32'h0000_0040, 1, 0, 16'h0200);
        chk("R3 message sent", {29'b0, msg_sev}, 32'h1);
        chk("R2 correctable detected", {31'b0, dev_status[0]}, 1);
        cfg_cor_mask = 32'h0000_0080;
        send(32'h0000_0080, 1, 0, 16'h0201);
        chk("R3 masked no msg", {31'b0, msg_valid}, 0);
        chk("R3 masked status set", {31'b0, cor_status[7]}, 1);
        cfg_cor_mask = 0; cfg_cor_rpt_en = 0;
        send(32'h0000_1000, 1, 0, 16'h0202);
        chk("R9 correctable enable off", {31'b0, msg_valid}, 0);

        // R4 severity
        do_reset();
        send(32'h0004_0000, 0, 0, 16'h0300);
        chk("R4 default fatal", {29'b0, msg_sev}, 32'h4);
        send(32'h0000_1000, 0, 0, 16'h0301);
        chk("R4 default non-fatal", {29'b0, msg_sev}, 32'h2);
        cfg_unc_sev = T_SEV_DEF | 32'h0000_1000;
        send(32'h0000_1000, 0, 0, 16'h0302);
        chk("R4 severity raised", {29'b0, msg_sev}, 32'h4);
        chk("R6 fatal detected", {31'b0, dev_status[2]}, 1);

        // R6 uncorrectable mask
        do_reset();
        cfg_unc_mask = 32'h0008_0000;
        send(32'h0008_0000, 0, 0, 16'h0400);
        chk("R6 masked no msg", {31'b0, msg_valid}, 0);
        chk("R6 masked no log", {31'b0, log_req}, 0);
        chk("R6 masked status", unc_status, 32'h0008_0000);
        chk("R6 non-fatal detected", {31'b0, dev_status[1]}, 1);

        // R7 uncorrectable gate
        cfg_nf_rpt_en = 0;
        send(32'h0000_4000, 0, 0, 16'h0401);
        chk("R7 non-fatal enable off", {31'b0, msg_valid}, 0);
        chk("R6 unmasked log", {31'b0, log_req}, 1);
        cfg_serr_en = 1;
        send(32'h0000_4000, 0, 0, 16'h0402);
        chk("R7 serr releases", {29'b0, msg_sev}, 32'h2);

        // R8 unsupported request
        do_reset();
        cfg_ur_rpt_en = 0;
        send(32'h0010_0000, 0, 0, 16'h0500);
        chk("R8 UR dropped", {31'b0, msg_valid}, 0);
        chk("R2 UR detected", {31'b0, dev_status[3]}, 1);
        cfg_serr_en = 1;
        send(32'h0010_0000, 0, 0, 16'h0501);
        chk("R8 UR with serr", {29'b0, msg_sev}, 32'h2);
        send(32'h0010_0000, 0, 1, 16'h0502);
        chk("R8 advisory UR dropped", {31'b0, msg_valid}, 0);
        chk("R5 advisory UR cor bit", {31'b0, cor_status[13]}, 1);

        // R5 advisory
        do_reset();
        send(32'h0000_4000, 0, 1, 16'h0600);
        chk("R5 advisory correctable msg", {29'b0, msg_sev}, 32'h1);
        chk("R5 advisory logged", {31'b0, log_req}, 1);
        chk("R5 advisory unc bit", unc_status, 32'h0000_4000);
        chk("R5 no non-fatal detected", {31'b0, dev_status[1]}, 0);
        cfg_unc_mask = 32'h0000_8000;
        send(32'h0000_8000, 0, 1, 16'h0601);
        chk("R5 masked advisory no log", {31'b0, log_req}, 0);
        chk("R5 masked advisory no unc", {31'b0, unc_status[15]}, 0);
        send(32'h0040_0000, 0, 1, 16'h0602);
        chk("R5 fatal ignores advisory", {29'b0, msg_sev}, 32'h4);

        // R10, R12 overflow follow-up
        do_reset();
        @(negedge clk);
        evt_valid = 1; evt_status = 32'h0000_1000; evt_correctable = 0;
        evt_source = 16'hBEEF; log_full = 1;
        @(negedge clk);
        chk("R12 stall", {31'b0, evt_ready}, 0);
        chk("R10 first event msg", {16'b0, msg_source}, 32'hBEEF);
        evt_status = 32'h0000_0001; evt_correctable = 1;
        evt_source = 16'h1234; log_full = 0;
        @(negedge clk);
        chk("R10 overflow msg", {29'b0, msg_sev}, 32'h1);
        chk("R10 overflow source", {16'b0, msg_source}, 32'hBEEF);
        chk("R10 overflow bit", {31'b0, cor_status[15]}, 1);
        chk("R12 stalled event not taken", {31'b0, cor_status[0]}, 0);
        chk("R12 ready again", {31'b0, evt_ready}, 1);
        @(negedge clk);
        evt_valid = 0;
        chk("R12 held event taken", {16'b0, msg_source}, 32'h1234);
        repeat (3) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule